// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the pre-divider N and the feedback multiplier M of a clock synthesizer. It takes a reference frequency and a desired output frequency, both as integers in Hz. It tries each admissible N in rising order and derives the matching M. It then works out the oscillator frequency that this pair would give and keeps the pair whose frequency lands closest to the desired one. All arithmetic is integer. Candidates are handled one at a time, and every product and quotient goes through a single shared multi-cycle restoring divider.

A search begins with a one-cycle `start` pulse while the block is idle. The block raises `busy` for the whole search. It then pulses `done` and presents the chosen N, the chosen M, the oscillator frequency and the rate rounded up to whole megabits per second. If no pair qualifies, it raises the error flag instead.

Top module: `pll_div_search`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0, and `best_n`, `best_m`, `fvco_hz` and `rate_mbps` are 0.
- R2: N takes every integer from ceil(fref / 40 MHz) up to floor(fref / 5 MHz), inclusive. If this range is empty (for example when fref is below 5 MHz), the search ends with `err` = 1.
- R3: For each N, M = floor(ftarget * N / fref). A candidate whose M is below 6 or above 512 is skipped, and this check is made on M before it is made even.
- R4: An odd M that passed the range check is increased by one, so every reported M is even.
- R5: The oscillator frequency is floor(M * fref / N). A candidate is rejected unless this lies within 80 MHz to 1500 MHz, both ends included.
- R6: The reported pair has the smallest absolute difference between oscillator frequency and ftarget. A later N replaces the held one only when its difference is strictly smaller, so on a tie the smallest N is kept.
- R7: When no candidate qualifies, `err` = 1 with `done`, and `best_n`, `best_m`, `fvco_hz` and `rate_mbps` are all 0.
- R8: On success, `rate_mbps` = ceil(fvco_hz / 1,000,000).
- R9: A `start` pulse while idle captures both frequencies and sets `busy` from the next cycle. `done` is high for exactly one cycle at the end. The result outputs hold their values until the next `done`.
- R10: A `start` pulse while a search is running is ignored, and the running search completes with its own inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search (used only while idle) |
| fref_hz | input | 32 | Reference frequency in Hz |
| ftarget_hz | input | 32 | Desired oscillator frequency in Hz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| err | output | 1 | No qualifying candidate |
| best_n | output | 10 | Chosen pre-divider |
| best_m | output | 10 | Chosen feedback multiplier (even) |
| fvco_hz | output | 32 | Oscillator frequency of the chosen pair |
| rate_mbps | output | 12 | Oscillator frequency rounded up to whole Mbps |

## Verification
The bench builds the block with its default parameters: 32-bit frequencies, a 5 to 40 MHz pre-divided reference window, an 80 to 1500 MHz oscillator window and a multiplier range of 6 to 512. With references from 4 to 27 MHz, this leaves between zero and five candidates per search. Every candidate can therefore be worked out by hand, and the stimuli are chosen so that each rule decides the result. A later N beats an earlier one. Exact ties keep N = 1. A raw M of 5 must be skipped before it is made even. The oscillator frequency sits exactly on the 1500 MHz limit. A frequency of 499.5 MHz must round up to 500 Mbps. Three inputs leave no candidate at all.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_NMIN,
        S_NMAX,
        S_MDIV,
        S_FDIV,
        S_RATE,
        S_DONE
    } search_st_e;

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div #(
    parameter int DVD_W = 64,
    parameter int DVS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DVS_W-1:0] divisor,
    output logic             done,
    output logic [DVD_W-1:0] quotient,
    output logic [DVS_W-1:0] remainder
);
    localparam int CNT_W = $clog2(DVD_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [DVD_W-1:0] quo;
        logic [DVS_W:0]   rem;
        logic [DVS_W-1:0] dvs;
    } div_state_t;

    div_state_t q, d;
    logic [DVS_W:0] rem_sh;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        rem_sh = '0;
        if (start) begin
            d.busy = 1'b1;
            d.cnt  = '0;
            d.quo  = dividend;
            d.rem  = '0;
            d.dvs  = divisor;
        end else if (q.busy) begin
            rem_sh = {q.rem[DVS_W-1:0], q.quo[DVD_W-1]};
            d.quo  = {q.quo[DVD_W-2:0], 1'b0};
            if (rem_sh >= {1'b0, q.dvs}) begin
                d.rem    = rem_sh - {1'b0, q.dvs};
                d.quo[0] = 1'b1;
            end else begin
                d.rem = rem_sh;
            end
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == CNT_W'(DVD_W - 1)) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done      = q.done;
    assign quotient  = q.quo;
    assign remainder = q.rem[DVS_W-1:0];

    // R3
    rem_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done && q.dvs != '0) |-> (q.rem < {1'b0, q.dvs}));

    // R9
    step_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> (q.cnt < CNT_W'(DVD_W)));

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int              QW         = 64,
    parameter int              FREQ_W     = 32,
    parameter int              M_W        = 10,
    parameter longint unsigned M_MIN      = 6,
    parameter longint unsigned M_MAX      = 512,
    parameter longint unsigned VCO_MIN_HZ = 80_000_000,
    parameter longint unsigned VCO_MAX_HZ = 1_500_000_000
) (
    input  logic [QW-1:0]     quo,
    input  logic [FREQ_W-1:0] ftgt,
    input  logic [FREQ_W:0]   best_delta,
    input  logic              found,
    output logic              m_ok,
    output logic [M_W-1:0]    m_even,
    output logic              vco_ok,
    output logic [FREQ_W:0]   delta,
    output logic              improve
);
    logic [QW-1:0] tgt_w;
    logic [QW-1:0] diff;

    always_comb begin
        // range check uses the raw quotient, before the even adjustment
        m_ok    = (quo >= QW'(M_MIN)) && (quo <= QW'(M_MAX));
        m_even  = quo[M_W-1:0] + M_W'(quo[0]);
        vco_ok  = (quo >= QW'(VCO_MIN_HZ)) && (quo <= QW'(VCO_MAX_HZ));
        tgt_w   = QW'(ftgt);
        diff    = (quo > tgt_w) ? (quo - tgt_w) : (tgt_w - quo);
        delta   = diff[FREQ_W:0];
        improve = vco_ok && (!found || (delta < best_delta));
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
    parameter int              FREQ_W      = 32,
    parameter int              N_W         = 10,
    parameter int              M_W         = 10,
    parameter int              RATE_W      = 12,
    parameter longint unsigned PFD_MIN_HZ  = 5_000_000,
    parameter longint unsigned PFD_MAX_HZ  = 40_000_000,
    parameter longint unsigned VCO_MIN_HZ  = 80_000_000,
    parameter longint unsigned VCO_MAX_HZ  = 1_500_000_000,
    parameter longint unsigned M_MIN       = 6,
    parameter longint unsigned M_MAX       = 512,
    parameter longint unsigned HZ_PER_UNIT = 1_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] fref_hz,
    input  logic [FREQ_W-1:0] ftarget_hz,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [N_W-1:0]    best_n,
    output logic [M_W-1:0]    best_m,
    output logic [FREQ_W-1:0] fvco_hz,
    output logic [RATE_W-1:0] rate_mbps
);
    import pll_search_pkg::*;

    localparam int DW      = 2 * FREQ_W;
    localparam int DELTA_W = FREQ_W + 1;

    typedef struct packed {
        search_st_e         st;
        logic [FREQ_W-1:0]  fref;
        logic [FREQ_W-1:0]  ftgt;
        logic [N_W-1:0]     n_min;
        logic [N_W-1:0]     n_max;
        logic [N_W-1:0]     n;
        logic [M_W-1:0]     m_cur;
        logic               found;
        logic [DELTA_W-1:0] cand_delta;
        logic [N_W-1:0]     cand_n;
        logic [M_W-1:0]     cand_m;
        logic [FREQ_W-1:0]  cand_fvco;
        logic               res_err;
        logic [N_W-1:0]     res_n;
        logic [M_W-1:0]     res_m;
        logic [FREQ_W-1:0]  res_fvco;
        logic [RATE_W-1:0]  res_rate;
        logic               div_go;
        logic [DW-1:0]      div_a;
        logic [FREQ_W-1:0]  div_b;
    } top_state_t;

    top_state_t q, d;

    logic               div_done;
    logic [DW-1:0]      div_q;
    logic [FREQ_W-1:0]  div_r;
    logic               m_ok, vco_ok, improve;
    logic [M_W-1:0]     m_even;
    logic [DELTA_W-1:0] delta;
    logic               adv, fin, fin_err;

    pll_seq_div #(
        .DVD_W (DW),
        .DVS_W (FREQ_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (q.div_go),
        .dividend  (q.div_a),
        .divisor   (q.div_b),
        .done      (div_done),
        .quotient  (div_q),
        .remainder (div_r)
    );

    pll_cand_eval #(
        .QW         (DW),
        .FREQ_W     (FREQ_W),
        .M_W        (M_W),
        .M_MIN      (M_MIN),
        .M_MAX      (M_MAX),
        .VCO_MIN_HZ (VCO_MIN_HZ),
        .VCO_MAX_HZ (VCO_MAX_HZ)
    ) u_eval (
        .quo        (div_q),
        .ftgt       (q.ftgt),
        .best_delta (q.cand_delta),
        .found      (q.found),
        .m_ok       (m_ok),
        .m_even     (m_even),
        .vco_ok     (vco_ok),
        .delta      (delta),
        .improve    (improve)
    );

    always_comb begin
        d        = q;
        d.div_go = 1'b0;
        adv      = 1'b0;
        fin      = 1'b0;
        fin_err  = 1'b0;
        unique case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.fref       = fref_hz;
                    d.ftgt       = ftarget_hz;
                    d.found      = 1'b0;
                    d.cand_delta = '0;
                    d.st         = S_NMIN;
                    d.div_go     = 1'b1;
                    d.div_a      = DW'(fref_hz);
                    d.div_b      = FREQ_W'(PFD_MAX_HZ);
                end
            end
            S_NMIN: begin
                if (div_done) begin
                    d.n_min  = N_W'(div_q) + N_W'(div_r != '0);
                    d.st     = S_NMAX;
                    d.div_go = 1'b1;
                    d.div_a  = DW'(q.fref);
                    d.div_b  = FREQ_W'(PFD_MIN_HZ);
                end
            end
            S_NMAX: begin
                if (div_done) begin
                    d.n_max = N_W'(div_q);
                    if (d.n_max == '0 || q.n_min > d.n_max) begin
                        fin     = 1'b1;
                        fin_err = 1'b1;
                    end else begin
                        d.n      = q.n_min;
                        d.st     = S_MDIV;
                        d.div_go = 1'b1;
                        d.div_a  = DW'(q.ftgt) * DW'(q.n_min);
                        d.div_b  = q.fref;
                    end
                end
            end
            S_MDIV: begin
                if (div_done) begin
                    d.m_cur = m_even;
                    if (m_ok) begin
                        d.st     = S_FDIV;
                        d.div_go = 1'b1;
                        d.div_a  = DW'(m_even) * DW'(q.fref);
                        d.div_b  = FREQ_W'(q.n);
                    end else begin
                        adv = 1'b1;
                    end
                end
            end
            S_FDIV: begin
                if (div_done) begin
                    if (improve) begin
                        d.found      = 1'b1;
                        d.cand_delta = delta;
                        d.cand_n     = q.n;
                        d.cand_m     = q.m_cur;
                        d.cand_fvco  = FREQ_W'(div_q);
                    end
                    adv = 1'b1;
                end
            end
            S_RATE: begin
                if (div_done) begin
                    d.res_err  = 1'b0;
                    d.res_n    = q.cand_n;
                    d.res_m    = q.cand_m;
                    d.res_fvco = q.cand_fvco;
                    d.res_rate = RATE_W'(div_q) + RATE_W'(div_r != '0);
                    d.st       = S_DONE;
                end
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase

        if (adv) begin
            if (q.n == q.n_max) begin
                if (d.found) begin
                    d.st     = S_RATE;
                    d.div_go = 1'b1;
                    d.div_a  = DW'(d.cand_fvco);
                    d.div_b  = FREQ_W'(HZ_PER_UNIT);
                end else begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                end
            end else begin
                d.n      = q.n + 1'b1;
                d.st     = S_MDIV;
                d.div_go = 1'b1;
                d.div_a  = DW'(q.ftgt) * DW'(q.n + 1'b1);
                d.div_b  = q.fref;
            end
        end

        if (fin) begin
            d.st       = S_DONE;
            d.res_err  = fin_err;
            d.res_n    = '0;
            d.res_m    = '0;
            d.res_fvco = '0;
            d.res_rate = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign done      = (q.st == S_DONE);
    assign err       = q.res_err;
    assign best_n    = q.res_n;
    assign best_m    = q.res_m;
    assign fvco_hz   = q.res_fvco;
    assign rate_mbps = q.res_rate;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R4
    m_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> !best_m[0]);

    // R3
    m_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (DW'(best_m) >= DW'(M_MIN) && DW'(best_m) <= DW'(M_MAX)));

    // R5
    vco_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (DW'(fvco_hz) >= DW'(VCO_MIN_HZ) && DW'(fvco_hz) <= DW'(VCO_MAX_HZ)));

    // R2
    pfd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (DW'(q.fref) >= DW'(best_n) * DW'(PFD_MIN_HZ) &&
                            DW'(q.fref) <= DW'(best_n) * DW'(PFD_MAX_HZ)));

    // R7
    err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (best_n == '0 && best_m == '0 && fvco_hz == '0 && rate_mbps == '0));

endmodule

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] fref = '0;
    logic [31:0] ftgt = '0;
    logic        busy, done, err;
    logic [9:0]  best_n, best_m;
    logic [31:0] fvco_hz;
    logic [11:0] rate_mbps;

    int checks = 0;
    int errors = 0;
    logic busy_seen;

    always #2.5 clk = ~clk;

    pll_div_search u_pll_div_search (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .fref_hz    (fref),
        .ftarget_hz (ftgt),
        .busy       (busy),
        .done       (done),
        .err        (err),
        .best_n     (best_n),
        .best_m     (best_m),
        .fvco_hz    (fvco_hz),
        .rate_mbps  (rate_mbps)
    );

    // columns: fref, ftarget, err, n, m, fvco, rate
    localparam int NV = 8;
    localparam longint unsigned VEC [NV][7] = '{
        '{24_000_000, 1_000_000_000, 0, 4, 166,   996_000_000,  996}, // R6 later N wins, R4 odd 41
        '{24_000_000, 1_008_000_000, 0, 1,  42, 1_008_000_000, 1008}, // R6 tie keeps N=1
        '{15_000_000,    89_000_000, 0, 2,  12,    90_000_000,   90}, // R3 raw M=5 skipped
        '{27_000_000,   500_000_000, 0, 4,  74,   499_500_000,  500}, // R8 round up
        '{25_000_000, 1_500_000_000, 0, 1,  60, 1_500_000_000, 1500}, // R5 upper limit kept
        '{24_000_000,    50_000_000, 1, 0,   0,             0,    0}, // R5 low, R7
        '{24_000_000, 1_600_000_000, 1, 0,   0,             0,    0}, // R5 high, R7
        '{ 4_000_000,   100_000_000, 1, 0,   0,             0,    0}  // R2 empty range
    };

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic launch(input longint unsigned fr, input longint unsigned ft);
        @(negedge clk);
        fref  = 32'(fr);
        ftgt  = 32'(ft);
        start = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        busy_seen = busy;
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 50000);
        end
    endtask

    task automatic check_result(input int i, input string tag);
        chk({tag, " err"},  err,       VEC[i][2]);
        chk({tag, " n"},    best_n,    VEC[i][3]);
        chk({tag, " m"},    best_m,    VEC[i][4]);
        chk({tag, " fvco"}, fvco_hz,   VEC[i][5]);
        chk({tag, " rate"}, rate_mbps, VEC[i][6]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 global watchdog actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 err",  err,  0);
        chk("R1 n",    best_n, 0);
        chk("R1 rate", rate_mbps, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            launch(VEC[i][0], VEC[i][1]);
            chk("R9 busy after start", busy_seen, 1);
            wait_done();
            check_result(i, $sformatf("R6 R7 vector %0d", i));
            @(negedge clk);
            chk("R9 done one cycle", done, 0);
        end

        // R9 results held after done
        launch(VEC[3][0], VEC[3][1]);
        wait_done();
        repeat (10) @(negedge clk);
        chk("R9 held n", best_n, 4);
        chk("R9 held rate", rate_mbps, 500);

        // R10 start during a search is ignored
        launch(VEC[0][0], VEC[0][1]);
        repeat (30) @(negedge clk);
        chk("R10 still busy", busy, 1);
        fref  = 32'(VEC[3][0]);
        ftgt  = 32'(VEC[3][1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check_result(0, "R10 ignored start");
        @(negedge clk);
        chk("R10 idle after", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule